// File: doc/BRIEF.md
# Parallel-Port Bridge Register Access Sequencer

This block sits on the host side of a legacy parallel port that connects to an IDE bridge. On a single request it reads or writes one bridge register. It does this by stepping the port's data and control outputs through a fixed script and by capturing the port's status, control-return or data lines at chosen points in that script. Each request carries four things: the direction, a bit that picks the normal register file or the control-register file, a 7-bit register index, and a 2-bit transfer mode. The mode picks one of three read styles: nibble-wide status reads, a split 5/3 read across status and control-return lines, or a full byte read from the data lines. Writes use the same script in every mode.

The address placed on the data lines is scrambled with a constant that depends on the mode and the direction. Read data is rebuilt from the captured fragments, and each mode packs the bits in its own way. Every script operation takes one step. The step length is a number of clock cycles set by an input and latched when the request is accepted. While a script runs the block reports busy and ignores new requests. At the end it raises done for one cycle, and for a read it also updates the read data.

Top module: `ppreg_seq`

## Requirements
- R1: During reset and after it, pd_out is 0x00, ctl_out is 0x04, busy and done are 0, and rdata is 0x00.
- R2: The address byte is {req_ctl_file, req_index}, which adds 0x80 when the control file is chosen. It is XORed with 0x39 for a mode-0 read, 0x31 for a mode-1 read, 0x29 for a mode-2 read, and 0x19 for a write in any of modes 0 to 2.
- R3: A mode-0 read (req_mode=0) runs these operations in order: data←A, ctl←0x01, ctl←0x03, data←A, capture status as S1, ctl←0x01, capture status as S2, ctl←0x04. The result is {S2[7:4], S1[7:4]}.
- R4: A mode-1 read runs: data←A, ctl←0x01, data←A&0x37, ctl←0x03, ctl←0x05, data←A|0xF0, capture status as S, capture ctlin_in as C, ctl←0x04. The result is {C[3:1], S[7:3]}.
- R5: A mode-2 read runs: data←A, ctl←0x01, ctl←0x21, ctl←0x23, capture pdata_in as D, ctl←0x04. The result is D.
- R6: A write in modes 0 to 2 runs: data←A, ctl←0x01, data←req_wdata, ctl←0x03, ctl←0x04.
- R7: Every operation lasts L = max(step_len,1) cycles, with step_len latched at acceptance. The effect of operation k (counting from 0) appears (k+1)·L cycles after the accepting edge, and a capture samples the inputs at that edge. done pulses together with the last operation.
- R8: A request is accepted only while busy is 0. busy stays 1 from the accepting edge until the last operation, and a request presented while busy has no effect on the port outputs, the timing or the result.
- R9: A request with req_mode=3 completes in the cycle after acceptance: done=1, busy stays 0, rdata=0xFF, and pd_out and ctl_out do not change.
- R10: rdata changes only together with done. A write leaves it unchanged.
- R11: While idle, pd_out and ctl_out hold their values, and after any legal script ctl_out is left at 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctl_file | input | 1 | Selects the control-register file |
| req_index | input | 7 | Register index |
| req_wdata | input | 8 | Write value |
| req_mode | input | 2 | Transfer mode (0 nibble, 1 five/three, 2 byte, 3 illegal) |
| step_len | input | STEP_W | Cycles per operation (0 acts as 1) |
| status_in | input | 8 | Port status lines |
| ctlin_in | input | 8 | Port control lines read back |
| pdata_in | input | 8 | Port data lines read back |
| pd_out | output | 8 | Port data output |
| ctl_out | output | 8 | Port control output |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Assembled read value |

## Verification
The bench builds the block with STEP_W=4, so step lengths from 0 to 15 can all be reached. That covers the zero-means-one case and the longest step within a short run. The bench models the bridge: it shows one status byte while control is 0x01 and another at all other times. This makes the two mode-0 captures differ, so swapped capture order or swapped nibbles appear in the result. Junk requests and step-length changes are injected at random points in a running script to show that they have no effect.

// File: rtl/ppreg_pkg.sv
package ppreg_pkg;
  localparam int IDX_W   = 7;
  localparam int BYTE_W  = 8;
  localparam int MAX_OPS = 9;
  localparam int OPI_W   = $clog2(MAX_OPS);

  localparam logic [BYTE_W-1:0] KEY_RD_NIB  = 8'h39;
  localparam logic [BYTE_W-1:0] KEY_RD_53   = 8'h31;
  localparam logic [BYTE_W-1:0] KEY_RD_BYTE = 8'h29;
  localparam logic [BYTE_W-1:0] KEY_WR      = 8'h19;
  localparam logic [BYTE_W-1:0] CTL_PARK    = 8'h04;
  localparam logic [BYTE_W-1:0] RD_ILLEGAL  = 8'hFF;

  typedef enum logic [1:0] {
    XM_NIBBLE = 2'd0,
    XM_FIVE3  = 2'd1,
    XM_BYTE   = 2'd2,
    XM_RSVD   = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    OP_DATA,
    OP_CTRL,
    OP_GRAB_A_STAT,
    OP_GRAB_B_STAT,
    OP_GRAB_B_CTLIN,
    OP_GRAB_A_DATA
  } op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [BYTE_W-1:0] val;
    logic              last;
  } op_t;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
endpackage

// File: rtl/ppreg_script.sv
module ppreg_script
  import ppreg_pkg::*;
(
  input  xfer_mode_e        mode,
  input  logic              is_write,
  input  logic [BYTE_W-1:0] addr_enc,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [OPI_W-1:0]  idx,
  output op_t               op
);
  function automatic op_t mk(op_kind_e k, logic [BYTE_W-1:0] v, logic l);
    op_t o;
    o.kind = k;
    o.val  = v;
    o.last = l;
    return o;
  endfunction

  logic [BYTE_W-1:0] addr_lo;
  logic [BYTE_W-1:0] addr_hi;

  assign addr_lo = addr_enc & 8'h37;
  assign addr_hi = addr_enc | 8'hF0;

  always_comb begin
    op = mk(OP_CTRL, CTL_PARK, 1'b1);
    if (is_write) begin
      case (int'(idx))
        0: op = mk(OP_DATA, addr_enc, 1'b0);
        1: op = mk(OP_CTRL, 8'h01,    1'b0);
        2: op = mk(OP_DATA, wdata,    1'b0);
        3: op = mk(OP_CTRL, 8'h03,    1'b0);
        default: op = mk(OP_CTRL, CTL_PARK, 1'b1);
      endcase
    end else begin
      case (mode)
        XM_NIBBLE: begin
          case (int'(idx))
            0: op = mk(OP_DATA,        addr_enc, 1'b0);
            1: op = mk(OP_CTRL,        8'h01,    1'b0);
            2: op = mk(OP_CTRL,        8'h03,    1'b0);
            3: op = mk(OP_DATA,        addr_enc, 1'b0);
            4: op = mk(OP_GRAB_A_STAT, 8'h00,    1'b0);
            5: op = mk(OP_CTRL,        8'h01,    1'b0);
            6: op = mk(OP_GRAB_B_STAT, 8'h00,    1'b0);
            default: op = mk(OP_CTRL, CTL_PARK, 1'b1);
          endcase
        end
        XM_FIVE3: begin
          case (int'(idx))
            0: op = mk(OP_DATA,         addr_enc, 1'b0);
            1: op = mk(OP_CTRL,         8'h01,    1'b0);
            2: op = mk(OP_DATA,         addr_lo,  1'b0);
            3: op = mk(OP_CTRL,         8'h03,    1'b0);
            4: op = mk(OP_CTRL,         8'h05,    1'b0);
            5: op = mk(OP_DATA,         addr_hi,  1'b0);
            6: op = mk(OP_GRAB_A_STAT,  8'h00,    1'b0);
            7: op = mk(OP_GRAB_B_CTLIN, 8'h00,    1'b0);
            default: op = mk(OP_CTRL, CTL_PARK, 1'b1);
          endcase
        end
        XM_BYTE: begin
          case (int'(idx))
            0: op = mk(OP_DATA,        addr_enc, 1'b0);
            1: op = mk(OP_CTRL,        8'h01,    1'b0);
            2: op = mk(OP_CTRL,        8'h21,    1'b0);
            3: op = mk(OP_CTRL,        8'h23,    1'b0);
            4: op = mk(OP_GRAB_A_DATA, 8'h00,    1'b0);
            default: op = mk(OP_CTRL, CTL_PARK, 1'b1);
          endcase
        end
        default: op = mk(OP_CTRL, CTL_PARK, 1'b1);
      endcase
    end
  end
endmodule

// File: rtl/ppreg_steptimer.sv
module ppreg_steptimer #(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [STEP_W-1:0] len,
  output logic              step_end
);
  logic [STEP_W-1:0] cnt_q, cnt_d;
  logic [STEP_W-1:0] lim;

  assign lim      = (len == '0) ? '0 : len - 1'b1;
  assign step_end = en && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (step_end) cnt_d = '0;
    else if (en)       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ppreg_assemble.sv
module ppreg_assemble
  import ppreg_pkg::*;
(
  input  xfer_mode_e        mode,
  input  logic [BYTE_W-1:0] frag_a,
  input  logic [BYTE_W-1:0] frag_b,
  output logic [BYTE_W-1:0] result
);
  always_comb begin
    case (mode)
      XM_NIBBLE: result = {frag_b[7:4], frag_a[7:4]};
      XM_FIVE3:  result = {frag_b[3:1], frag_a[7:3]};
      XM_BYTE:   result = frag_a;
      default:   result = RD_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/ppreg_seq.sv
module ppreg_seq
  import ppreg_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_ctl_file,
  input  logic [6:0]        req_index,
  input  logic [7:0]        req_wdata,
  input  logic [1:0]        req_mode,
  input  logic [STEP_W-1:0] step_len,
  input  logic [7:0]        status_in,
  input  logic [7:0]        ctlin_in,
  input  logic [7:0]        pdata_in,
  output logic [7:0]        pd_out,
  output logic [7:0]        ctl_out,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rdata
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  seq_state_e        state_q, state_d;
  logic [OPI_W-1:0]  idx_q, idx_d;
  xfer_mode_e        mode_q, mode_d;
  logic              wr_q, wr_d;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] wd_q, wd_d;
  logic [STEP_W-1:0] len_q, len_d;
  logic [BYTE_W-1:0] pd_q, pd_d;
  logic [BYTE_W-1:0] ctl_q, ctl_d;
  logic [BYTE_W-1:0] fa_q, fa_d;
  logic [BYTE_W-1:0] fb_q, fb_d;
  logic [BYTE_W-1:0] rd_q, rd_d;
  logic              done_q, done_d;

  logic              accept;
  logic              step_end;
  op_t               cur_op;
  logic [BYTE_W-1:0] assembled;
  xfer_mode_e        req_mode_e;
  logic [BYTE_W-1:0] key;

  assign req_mode_e = xfer_mode_e'(req_mode);
  assign accept     = req_valid && (state_q == ST_IDLE);

  always_comb begin
    if (req_write) key = KEY_WR;
    else begin
      case (req_mode_e)
        XM_NIBBLE: key = KEY_RD_NIB;
        XM_FIVE3:  key = KEY_RD_53;
        default:   key = KEY_RD_BYTE;
      endcase
    end
  end

  ppreg_steptimer #(.STEP_W(STEP_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (accept),
    .en       (state_q == ST_RUN),
    .len      (len_q),
    .step_end (step_end)
  );

  ppreg_script u_script (
    .mode     (mode_q),
    .is_write (wr_q),
    .addr_enc (addr_q),
    .wdata    (wd_q),
    .idx      (idx_q),
    .op       (cur_op)
  );

  ppreg_assemble u_asm (
    .mode   (mode_q),
    .frag_a (fa_q),
    .frag_b (fb_q),
    .result (assembled)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    mode_d  = mode_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wd_d    = wd_q;
    len_d   = len_q;
    pd_d    = pd_q;
    ctl_d   = ctl_q;
    fa_d    = fa_q;
    fb_d    = fb_q;
    rd_d    = rd_q;
    done_d  = 1'b0;
    if (accept) begin
      if (req_mode_e == XM_RSVD) begin
        done_d = 1'b1;
        rd_d   = RD_ILLEGAL;
      end else begin
        state_d = ST_RUN;
        idx_d   = '0;
        mode_d  = req_mode_e;
        wr_d    = req_write;
        addr_d  = {req_ctl_file, req_index} ^ key;
        wd_d    = req_wdata;
        len_d   = step_len;
      end
    end else if (state_q == ST_RUN && step_end) begin
      case (cur_op.kind)
        OP_DATA:         pd_d  = cur_op.val;
        OP_CTRL:         ctl_d = cur_op.val;
        OP_GRAB_A_STAT:  fa_d  = status_in;
        OP_GRAB_B_STAT:  fb_d  = status_in;
        OP_GRAB_B_CTLIN: fb_d  = ctlin_in;
        OP_GRAB_A_DATA:  fa_d  = pdata_in;
        default:         ctl_d = ctl_q;
      endcase
      if (cur_op.last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        if (!wr_q) rd_d = assembled;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mode_q  <= XM_NIBBLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      len_q   <= '0;
      pd_q    <= '0;
      ctl_q   <= CTL_PARK;
      fa_q    <= '0;
      fb_q    <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      mode_q  <= mode_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wd_q    <= wd_d;
      len_q   <= len_d;
      pd_q    <= pd_d;
      ctl_q   <= ctl_d;
      fa_q    <= fa_d;
      fb_q    <= fb_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
    end
  end

  assign pd_out  = pd_q;
  assign ctl_out = ctl_q;
  assign busy    = (state_q == ST_RUN);
  assign done    = done_q;
  assign rdata   = rd_q;
endmodule

// File: rtl/ppreg_seq_chk.sv
module ppreg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [7:0] pd_out,
  input logic [7:0] ctl_out,
  input logic       busy,
  input logic       done,
  input logic [7:0] rdata
);
  // R11
  idle_ports_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(pd_out) && $stable(ctl_out)));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);

  // R11
  ctl_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> (ctl_out == 8'h04));
endmodule

bind ppreg_seq ppreg_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .pd_out    (pd_out),
  .ctl_out   (ctl_out),
  .busy      (busy),
  .done      (done),
  .rdata     (rdata)
);

// File: tb/sim_ppreg_seq.sv
module sim_ppreg_seq;
  localparam int STEP_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_ctl_file;
  logic [6:0] req_index;
  logic [7:0] req_wdata;
  logic [1:0] req_mode;
  logic [STEP_W-1:0] step_len;
  logic [7:0] status_in, ctlin_in, pdata_in;
  logic [7:0] pd_out, ctl_out, rdata;
  logic busy, done;

  logic [7:0] br_sa, br_sb, br_cb, br_dt;

  always #2 clk = ~clk;

  // bridge model: status depends on the control lines
  assign status_in = (ctl_out == 8'h01) ? br_sb : br_sa;
  assign ctlin_in  = br_cb;
  assign pdata_in  = br_dt;

  ppreg_seq #(.STEP_W(STEP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ctl_file(req_ctl_file), .req_index(req_index), .req_wdata(req_wdata),
    .req_mode(req_mode), .step_len(step_len), .status_in(status_in),
    .ctlin_in(ctlin_in), .pdata_in(pdata_in), .pd_out(pd_out),
    .ctl_out(ctl_out), .busy(busy), .done(done), .rdata(rdata)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] e_pd [9];
  logic [7:0] e_ctl[9];
  int         e_n;
  logic [7:0] e_rd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    wrap_up();
  end

  function automatic logic [7:0] key_of(int mode, bit wr);
    if (wr) return 8'h19;
    case (mode)
      0: return 8'h39;
      1: return 8'h31;
      default: return 8'h29;
    endcase
  endfunction

  task automatic setp(int k, logic [7:0] p, logic [7:0] c);
    e_pd[k] = p; e_ctl[k] = c;
  endtask

  task automatic build(int mode, bit wr, bit fl, logic [6:0] ix, logic [7:0] wd,
                       logic [7:0] c0);
    logic [7:0] a;
    a = {fl, ix} ^ key_of(mode, wr);
    if (wr) begin
      e_n = 5;
      setp(0, a, c0); setp(1, a, 8'h01); setp(2, wd, 8'h01);
      setp(3, wd, 8'h03); setp(4, wd, 8'h04);
    end else if (mode == 0) begin
      e_n = 8;
      setp(0, a, c0); setp(1, a, 8'h01); setp(2, a, 8'h03); setp(3, a, 8'h03);
      setp(4, a, 8'h03); setp(5, a, 8'h01); setp(6, a, 8'h01); setp(7, a, 8'h04);
      e_rd = {br_sb[7:4], br_sa[7:4]};
    end else if (mode == 1) begin
      e_n = 9;
      setp(0, a, c0); setp(1, a, 8'h01); setp(2, a & 8'h37, 8'h01);
      setp(3, a & 8'h37, 8'h03); setp(4, a & 8'h37, 8'h05);
      setp(5, a | 8'hF0, 8'h05); setp(6, a | 8'hF0, 8'h05);
      setp(7, a | 8'hF0, 8'h05); setp(8, a | 8'hF0, 8'h04);
      e_rd = {br_cb[3:1], br_sa[7:3]};
    end else begin
      e_n = 6;
      setp(0, a, c0); setp(1, a, 8'h01); setp(2, a, 8'h21); setp(3, a, 8'h23);
      setp(4, a, 8'h23); setp(5, a, 8'h04);
      e_rd = br_dt;
    end
  endtask

  task automatic run_txn(int mode, bit wr, bit fl, logic [6:0] ix, logic [7:0] wd,
                         int sl, int poke_j, int new_sl);
    logic [7:0] c0, p0, rd0;
    int L, tot;
    string tg;
    @(negedge clk);
    br_sa = 8'($urandom); br_sb = 8'($urandom);
    br_cb = 8'($urandom); br_dt = 8'($urandom);
    c0 = ctl_out; p0 = pd_out; rd0 = rdata;
    req_valid = 1'b1; req_write = wr; req_ctl_file = fl; req_index = ix;
    req_wdata = wd; req_mode = 2'(mode); step_len = STEP_W'(sl);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (mode == 3) begin
      chk("R9 done", 32'(done), 1);
      chk("R9 busy", 32'(busy), 0);
      chk("R9 rdata", 32'(rdata), 32'hFF);
      chk("R9 pd_out", 32'(pd_out), 32'(p0));
      chk("R9 ctl_out", 32'(ctl_out), 32'(c0));
      @(posedge clk); @(negedge clk);
      chk("R9 done pulse", 32'(done), 0);
      return;
    end
    L = (sl == 0) ? 1 : sl;
    tg = wr ? "R6" : (mode == 0 ? "R3" : (mode == 1 ? "R4" : "R5"));
    build(mode, wr, fl, ix, wd, c0);
    tot = e_n * L;
    chk("R8 busy at accept", 32'(busy), 1);
    for (int j = 1; j <= tot; j++) begin
      if (j == poke_j) begin
        req_valid = 1'b1; req_write = ~wr; req_index = 7'($urandom);
        req_wdata = 8'($urandom); req_mode = 2'($urandom); req_ctl_file = ~fl;
        step_len = STEP_W'(new_sl);
      end
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      if (j % L == 0) begin
        int k;
        k = j / L - 1;
        chk(k == 0 ? "R2 address" : {tg, " pd_out"}, 32'(pd_out), 32'(e_pd[k]));
        chk({tg, " ctl_out"}, 32'(ctl_out), 32'(e_ctl[k]));
      end
      if (j < tot) begin
        chk("R8 busy held", 32'(busy), 1);
        chk("R7 done early", 32'(done), 0);
      end else begin
        chk("R7 done", 32'(done), 1);
        chk("R7 busy clear", 32'(busy), 0);
        if (wr) chk("R10 rdata kept", 32'(rdata), 32'(rd0));
        else    chk({tg, " rdata"}, 32'(rdata), 32'(e_rd));
      end
    end
    @(posedge clk); @(negedge clk);
    chk("R7 done one cycle", 32'(done), 0);
  endtask

  task automatic idle_hold();
    logic [7:0] p, c, r;
    p = pd_out; c = ctl_out; r = rdata;
    br_sa = ~br_sa; br_sb = ~br_sb; br_cb = ~br_cb; br_dt = ~br_dt;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R11 idle pd_out", 32'(pd_out), 32'(p));
    chk("R11 idle ctl_out", 32'(ctl_out), 32'(c));
    chk("R10 idle rdata", 32'(rdata), 32'(r));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_ctl_file = 1'b0;
    req_index = '0; req_wdata = '0; req_mode = '0; step_len = '0;
    br_sa = 8'h00; br_sb = 8'h00; br_cb = 8'h00; br_dt = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pd_out", 32'(pd_out), 0);
    chk("R1 ctl_out", 32'(ctl_out), 32'h04);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 rdata", 32'(rdata), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 ctl_out after release", 32'(ctl_out), 32'h04);
    chk("R1 busy after release", 32'(busy), 0);

    // directed corners
    run_txn(0, 0, 0, 7'h05, 8'h00, 1, 0, 0);
    run_txn(1, 0, 1, 7'h7F, 8'h00, 3, 4, 9);
    run_txn(2, 0, 0, 7'h00, 8'h00, 0, 2, 7);
    idle_hold();
    run_txn(0, 1, 1, 7'h12, 8'hA5, 2, 3, 1);
    run_txn(2, 1, 0, 7'h33, 8'h5A, 15, 75, 2);
    run_txn(3, 0, 0, 7'h01, 8'h00, 4, 0, 0);
    run_txn(3, 1, 1, 7'h02, 8'h11, 4, 0, 0);
    run_txn(1, 1, 0, 7'h44, 8'h3C, 1, 5, 15);
    idle_hold();

    // constrained random
    for (int t = 0; t < 300; t++) begin
      int m, s, pj;
      m  = int'($urandom % 4);
      s  = int'($urandom % 16);
      pj = int'($urandom % 40);
      run_txn(m, 1'($urandom), 1'($urandom), 7'($urandom), 8'($urandom),
              s, pj, int'($urandom % 16));
      if (t % 50 == 0) idle_hold();
    end
    wrap_up();
  end
endmodule